// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the combinational hazard logic of a five-stage, 32-bit integer pipeline. It compares the two source register numbers of the instruction in decode with the destinations of the instructions in execute, memory and writeback. It returns three things: an operand-select code for each ALU operand, a flag per operand that routes the memory-stage result into the decode-stage branch comparator, and one stall request. The stall freezes fetch and decode and injects a bubble into execute.

The ALU selects apply to the instruction now in decode and are registered into execute with it. A producer in execute will sit in memory by then, so it selects the memory-stage value. A producer in memory will sit in writeback, so it selects the writeback-stage value. The register file is assumed to pass a same-cycle write through to its read ports. The instruction carries separate need flags for its ALU operands and for its branch or register-jump operands. The caller sets the ALU rt flag for stores, because a store uses rt as its data. A mode input chooses between stall-plus-forward, which is the default at value 0, and stall-only.

Top module: `hzd_unit`

## Requirements
- R1: The select code per ALU operand is 2'b00 for the register-file value, 2'b01 for the writeback-stage value and 2'b10 for the memory-stage value; 2'b11 never appears, and the rs and rt selects are computed independently.
- R2: In mode 0, an ALU-needed operand that equals the execute-stage destination gets select 2'b10.
- R3: In mode 0, an ALU-needed operand that equals the memory-stage destination gets select 2'b01, unless it also equals the execute-stage destination, in which case 2'b10 wins.
- R4: Source register 0 never produces a non-zero select, a branch flag or a stall.
- R5: A stage is a producer only while its write-enable is 1, and an operand counts only while its need flag is 1.
- R6: In mode 0, stall is 1 when the execute-stage instruction is a load (memory-read 1) whose destination equals an operand needed by the ALU or by a branch/jump.
- R7: In mode 0, a branch/jump-needed operand that equals the memory-stage destination, and does not equal the execute-stage destination, raises that operand's branch flag (rs and rt flags are separate).
- R8: In mode 0, a branch/jump-needed operand that equals the execute-stage destination raises stall and clears that operand's branch flag.
- R9: In mode 1 (stall-only), both selects are 2'b00, both branch flags are 0, and stall is 1 when any needed operand equals the destination of the execute, memory or writeback stage.
- R10: In mode 0, a match against the writeback stage alone gives select 2'b00 and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | 0: stall plus forwarding, 1: stall only |
| id_rs_i | input | RA_W | Decode-stage rs register number |
| id_rt_i | input | RA_W | Decode-stage rt register number |
| alu_rs_need_i | input | 1 | ALU reads rs |
| alu_rt_need_i | input | 1 | ALU reads rt (also set for stores) |
| bj_rs_need_i | input | 1 | Branch/register-jump reads rs |
| bj_rt_need_i | input | 1 | Branch reads rt |
| ex_dst_i | input | RA_W | Execute-stage destination register |
| ex_we_i | input | 1 | Execute-stage register write enable |
| ex_memread_i | input | 1 | Execute-stage instruction is a load |
| mem_dst_i | input | RA_W | Memory-stage destination register |
| mem_we_i | input | 1 | Memory-stage register write enable |
| wb_dst_i | input | RA_W | Writeback-stage destination register |
| wb_we_i | input | 1 | Writeback-stage register write enable |
| fwd_rs_o | output | 2 | ALU rs select code |
| fwd_rt_o | output | 2 | ALU rt select code |
| bj_fwd_rs_o | output | 1 | Route memory-stage value to branch rs |
| bj_fwd_rt_o | output | 1 | Route memory-stage value to branch rt |
| stall_o | output | 1 | Freeze fetch/decode, insert bubble |

## Verification
The embedded assertions run whenever an input changes. They check that code 2'b11 never appears and that register 0 never forwards. They check that stall-only mode keeps every select and flag at zero, that a load-use match always stalls, and that a branch flag never appears without its need flag. Priority between stages, the exact stage each select names, the way branch and ALU needs split, and the writeback stage being ignored in forwarding mode can only be shown by the bench's directed scenarios, which compare against values worked out from the requirements.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   typedef enum logic [1:0] {
      FWD_NONE = 2'b00,
      FWD_WB   = 2'b01,
      FWD_MEM  = 2'b10
   } fwd_sel_e;

   typedef enum logic {
      MODE_STALL_FWD  = 1'b0,
      MODE_STALL_ONLY = 1'b1
   } hz_mode_e;

   localparam int unsigned NUM_STAGES = 3;
   localparam int unsigned ST_EX  = 0;
   localparam int unsigned ST_MEM = 1;
   localparam int unsigned ST_WB  = 2;

endpackage

// File: rtl/hzd_stage_match.sv
module hzd_stage_match #(
   parameter int unsigned RA_W = 5
) (
   input  logic [RA_W-1:0] src_i,
   input  logic [RA_W-1:0] dst_i,
   input  logic            we_i,
   output logic            hit_o
);
   localparam logic [RA_W-1:0] ZERO_REG = '0;

   assign hit_o = we_i && (src_i != ZERO_REG) && (src_i == dst_i);

endmodule

// File: rtl/hzd_operand.sv
module hzd_operand
   import hzd_pkg::*;
#(
   parameter int unsigned RA_W = 5
) (
   input  hz_mode_e        mode_i,
   input  logic [RA_W-1:0] src_i,
   input  logic            alu_need_i,
   input  logic            bj_need_i,
   input  logic [RA_W-1:0] ex_dst_i,
   input  logic            ex_we_i,
   input  logic            ex_load_i,
   input  logic [RA_W-1:0] mem_dst_i,
   input  logic            mem_we_i,
   input  logic [RA_W-1:0] wb_dst_i,
   input  logic            wb_we_i,
   output fwd_sel_e        sel_o,
   output logic            bj_fwd_o,
   output logic            stall_o
);
   logic [RA_W-1:0]       dst_a [NUM_STAGES];
   logic [NUM_STAGES-1:0] we_a;
   logic [NUM_STAGES-1:0] hit;
   logic                  any_need;

   assign dst_a[ST_EX]  = ex_dst_i;
   assign dst_a[ST_MEM] = mem_dst_i;
   assign dst_a[ST_WB]  = wb_dst_i;
   assign we_a[ST_EX]   = ex_we_i;
   assign we_a[ST_MEM]  = mem_we_i;
   assign we_a[ST_WB]   = wb_we_i;
   assign any_need      = alu_need_i | bj_need_i;

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      hzd_stage_match #(.RA_W(RA_W)) u_match (
         .src_i (src_i),
         .dst_i (dst_a[s]),
         .we_i  (we_a[s]),
         .hit_o (hit[s])
      );
   end

   always_comb begin
      sel_o    = FWD_NONE;
      bj_fwd_o = 1'b0;
      stall_o  = 1'b0;
      if (mode_i == MODE_STALL_FWD) begin
         // youngest producer wins: execute-stage result is newest
         if (alu_need_i && hit[ST_EX]) begin
            sel_o = FWD_MEM;
         end else if (alu_need_i && hit[ST_MEM]) begin
            sel_o = FWD_WB;
         end
         bj_fwd_o = bj_need_i && hit[ST_MEM] && !hit[ST_EX];
         stall_o  = (any_need && hit[ST_EX] && ex_load_i)
                  || (bj_need_i && hit[ST_EX]);
      end else begin
         stall_o = any_need && (|hit);
      end
   end

   always_comb begin
      // R4: a zero source register never selects a bypass or stalls
      assert_zero_reg_quiet_R4: assert (src_i != '0 ||
         (sel_o == FWD_NONE && !bj_fwd_o && !stall_o))
         else $error("zero register produced a hazard action");
      // R6: a load producing a needed operand must hold decode
      assert_load_use_stall_R6: assert (!(mode_i == MODE_STALL_FWD && ex_load_i
         && ex_we_i && any_need && src_i != '0 && src_i == ex_dst_i) || stall_o)
         else $error("load-use dependency without stall");
      // R7: branch flag only for a branch-needed operand
      assert_bj_fwd_needs_flag_R7: assert (!bj_fwd_o || bj_need_i)
         else $error("branch forward without branch need");
      // R5: no selection without an ALU need
      assert_sel_needs_flag_R5: assert (sel_o == FWD_NONE || alu_need_i)
         else $error("ALU select without ALU need");
   end

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
   import hzd_pkg::*;
#(
   parameter int unsigned RA_W = 5
) (
   input  logic            mode_i,
   input  logic [RA_W-1:0] id_rs_i,
   input  logic [RA_W-1:0] id_rt_i,
   input  logic            alu_rs_need_i,
   input  logic            alu_rt_need_i,
   input  logic            bj_rs_need_i,
   input  logic            bj_rt_need_i,
   input  logic [RA_W-1:0] ex_dst_i,
   input  logic            ex_we_i,
   input  logic            ex_memread_i,
   input  logic [RA_W-1:0] mem_dst_i,
   input  logic            mem_we_i,
   input  logic [RA_W-1:0] wb_dst_i,
   input  logic            wb_we_i,
   output logic [1:0]      fwd_rs_o,
   output logic [1:0]      fwd_rt_o,
   output logic            bj_fwd_rs_o,
   output logic            bj_fwd_rt_o,
   output logic            stall_o
);
   localparam int unsigned NUM_OPS = 2;
   localparam int unsigned OP_RS   = 0;
   localparam int unsigned OP_RT   = 1;

   if (RA_W < 2 || RA_W > 8) begin : g_bad_width
      $error("hzd_unit: RA_W must lie in 2..8");
   end

   hz_mode_e            mode;
   logic [RA_W-1:0]     src_a  [NUM_OPS];
   logic [NUM_OPS-1:0]  alu_need;
   logic [NUM_OPS-1:0]  bj_need;
   fwd_sel_e            sel_a  [NUM_OPS];
   logic [NUM_OPS-1:0]  bj_fwd;
   logic [NUM_OPS-1:0]  op_stall;

   assign mode            = hz_mode_e'(mode_i);
   assign src_a[OP_RS]    = id_rs_i;
   assign src_a[OP_RT]    = id_rt_i;
   assign alu_need[OP_RS] = alu_rs_need_i;
   assign alu_need[OP_RT] = alu_rt_need_i;
   assign bj_need[OP_RS]  = bj_rs_need_i;
   assign bj_need[OP_RT]  = bj_rt_need_i;

   for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
      hzd_operand #(.RA_W(RA_W)) u_operand (
         .mode_i     (mode),
         .src_i      (src_a[o]),
         .alu_need_i (alu_need[o]),
         .bj_need_i  (bj_need[o]),
         .ex_dst_i   (ex_dst_i),
         .ex_we_i    (ex_we_i),
         .ex_load_i  (ex_memread_i),
         .mem_dst_i  (mem_dst_i),
         .mem_we_i   (mem_we_i),
         .wb_dst_i   (wb_dst_i),
         .wb_we_i    (wb_we_i),
         .sel_o      (sel_a[o]),
         .bj_fwd_o   (bj_fwd[o]),
         .stall_o    (op_stall[o])
      );
   end

   assign fwd_rs_o    = sel_a[OP_RS];
   assign fwd_rt_o    = sel_a[OP_RT];
   assign bj_fwd_rs_o = bj_fwd[OP_RS];
   assign bj_fwd_rt_o = bj_fwd[OP_RT];
   assign stall_o     = |op_stall;

   always_comb begin
      // R1: code 2'b11 is reserved and never driven
      assert_sel_legal_R1: assert (fwd_rs_o != 2'b11 && fwd_rt_o != 2'b11)
         else $error("illegal select code");
      // R9: stall-only mode never bypasses
      assert_stall_only_quiet_R9: assert (!mode_i ||
         (fwd_rs_o == 2'b00 && fwd_rt_o == 2'b00 && !bj_fwd_rs_o && !bj_fwd_rt_o))
         else $error("bypass active in stall-only mode");
      // R8: an execute-stage producer of a branch operand holds decode
      assert_bj_ex_stall_R8: assert (mode_i || !(bj_rs_need_i && ex_we_i
         && id_rs_i != '0 && id_rs_i == ex_dst_i) || stall_o)
         else $error("branch depends on execute stage without stall");
   end

endmodule

// File: tb/hzd_unit_tb.sv
module hzd_unit_tb;
   localparam int RA_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic            mode_i;
   logic [RA_W-1:0] id_rs_i, id_rt_i, ex_dst_i, mem_dst_i, wb_dst_i;
   logic            alu_rs_need_i, alu_rt_need_i, bj_rs_need_i, bj_rt_need_i;
   logic            ex_we_i, ex_memread_i, mem_we_i, wb_we_i;
   logic [1:0]      fwd_rs_o, fwd_rt_o;
   logic            bj_fwd_rs_o, bj_fwd_rt_o, stall_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   hzd_unit #(.RA_W(RA_W)) u_dut (
      .mode_i(mode_i), .id_rs_i(id_rs_i), .id_rt_i(id_rt_i),
      .alu_rs_need_i(alu_rs_need_i), .alu_rt_need_i(alu_rt_need_i),
      .bj_rs_need_i(bj_rs_need_i), .bj_rt_need_i(bj_rt_need_i),
      .ex_dst_i(ex_dst_i), .ex_we_i(ex_we_i), .ex_memread_i(ex_memread_i),
      .mem_dst_i(mem_dst_i), .mem_we_i(mem_we_i),
      .wb_dst_i(wb_dst_i), .wb_we_i(wb_we_i),
      .fwd_rs_o(fwd_rs_o), .fwd_rt_o(fwd_rt_o),
      .bj_fwd_rs_o(bj_fwd_rs_o), .bj_fwd_rt_o(bj_fwd_rt_o), .stall_o(stall_o)
   );

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear();
      mode_i = 1'b0; id_rs_i = '0; id_rt_i = '0;
      alu_rs_need_i = 0; alu_rt_need_i = 0; bj_rs_need_i = 0; bj_rt_need_i = 0;
      ex_dst_i = '0; ex_we_i = 0; ex_memread_i = 0;
      mem_dst_i = '0; mem_we_i = 0; wb_dst_i = '0; wb_we_i = 0;
   endtask

   task automatic settle();
      @(negedge clk);
      #2;
   endtask

   task automatic t_idle();
      clear(); settle();
      check("R1", "idle rs sel", fwd_rs_o, 0);
      check("R1", "idle rt sel", fwd_rt_o, 0);
      check("R1", "idle stall", stall_o, 0);
      check("R1", "idle bj flags", {bj_fwd_rs_o, bj_fwd_rt_o}, 0);
   endtask

   task automatic t_alu_forward();
      clear();
      id_rs_i = 5; alu_rs_need_i = 1; ex_dst_i = 5; ex_we_i = 1;
      id_rt_i = 7; alu_rt_need_i = 1; mem_dst_i = 7; mem_we_i = 1;
      settle();
      check("R2", "rs from execute producer", fwd_rs_o, 2);
      check("R3", "rt from memory producer", fwd_rt_o, 1);
      check("R1", "no stall for ALU bypass", stall_o, 0);
      mem_dst_i = 5;
      settle();
      check("R3", "execute beats memory", fwd_rs_o, 2);
      check("R1", "rt independent of rs", fwd_rt_o, 0);
   endtask

   task automatic t_zero_and_gating();
      clear();
      alu_rs_need_i = 1; bj_rs_need_i = 1; ex_dst_i = 0; ex_we_i = 1; ex_memread_i = 1;
      mem_dst_i = 0; mem_we_i = 1;
      settle();
      check("R4", "reg0 select", fwd_rs_o, 0);
      check("R4", "reg0 stall", stall_o, 0);
      check("R4", "reg0 bj flag", bj_fwd_rs_o, 0);
      clear();
      id_rs_i = 12; alu_rs_need_i = 1; ex_dst_i = 12; ex_we_i = 0;
      settle();
      check("R5", "write-enable off", fwd_rs_o, 0);
      ex_we_i = 1; alu_rs_need_i = 0;
      settle();
      check("R5", "need flag off", fwd_rs_o, 0);
   endtask

   task automatic t_load_use();
      clear();
      id_rt_i = 4; alu_rt_need_i = 1; ex_dst_i = 4; ex_we_i = 1; ex_memread_i = 1;
      settle();
      check("R6", "load-use ALU rt stall", stall_o, 1);
      ex_dst_i = 9;
      settle();
      check("R6", "unrelated load no stall", stall_o, 0);
      clear();
      id_rs_i = 8; bj_rs_need_i = 1; ex_dst_i = 8; ex_we_i = 1; ex_memread_i = 1;
      settle();
      check("R6", "load-use branch rs stall", stall_o, 1);
   endtask

   task automatic t_branch();
      clear();
      id_rs_i = 3; bj_rs_need_i = 1; mem_dst_i = 3; mem_we_i = 1;
      settle();
      check("R7", "branch rs memory flag", bj_fwd_rs_o, 1);
      check("R7", "branch rt flag idle", bj_fwd_rt_o, 0);
      check("R7", "no stall", stall_o, 0);
      check("R7", "ALU select untouched", fwd_rs_o, 0);
      clear();
      id_rt_i = 6; bj_rt_need_i = 1; mem_dst_i = 6; mem_we_i = 1;
      settle();
      check("R7", "branch rt memory flag", bj_fwd_rt_o, 1);
      ex_dst_i = 6; ex_we_i = 1;
      settle();
      check("R8", "execute dependency stall", stall_o, 1);
      check("R8", "flag cleared", bj_fwd_rt_o, 0);
   endtask

   task automatic t_stall_only();
      clear();
      mode_i = 1;
      id_rs_i = 5; alu_rs_need_i = 1; ex_dst_i = 5; ex_we_i = 1;
      settle();
      check("R9", "sel held 00", fwd_rs_o, 0);
      check("R9", "execute match stall", stall_o, 1);
      clear(); mode_i = 1;
      id_rt_i = 7; alu_rt_need_i = 1; mem_dst_i = 7; mem_we_i = 1;
      settle();
      check("R9", "memory match stall", stall_o, 1);
      check("R9", "rt sel held 00", fwd_rt_o, 0);
      clear(); mode_i = 1;
      id_rt_i = 7; alu_rt_need_i = 1; wb_dst_i = 7; wb_we_i = 1;
      settle();
      check("R9", "writeback match stall", stall_o, 1);
      clear(); mode_i = 1;
      id_rs_i = 3; bj_rs_need_i = 1; mem_dst_i = 3; mem_we_i = 1;
      settle();
      check("R9", "no branch flag", bj_fwd_rs_o, 0);
      check("R9", "branch dep stall", stall_o, 1);
   endtask

   task automatic t_writeback_ignored();
      clear();
      id_rs_i = 11; alu_rs_need_i = 1; bj_rs_need_i = 1; wb_dst_i = 11; wb_we_i = 1;
      settle();
      check("R10", "writeback only select", fwd_rs_o, 0);
      check("R10", "writeback only stall", stall_o, 0);
   endtask

   initial begin
      clear();
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_alu_forward();
      t_zero_and_gating();
      t_load_use();
      t_branch();
      t_stall_only();
      t_writeback_ignored();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule